// File: doc/BRIEF.md
# UART Request-to-Send Controller with Shadow Bit

This block owns the request-to-send state of a UART and drives the active-low `rts_no` pad. Software sets or clears that state in two ways: through the full modem control word, or through a one-bit alias register. The alias lets a driver change RTS alone, without a read-modify-write of the whole modem control word. Both paths reach the same storage flop, so a read through either one always returns the same value.

Two other bits of the modem control word change how the pad behaves. The first enables automatic flow control. When it is set and the receive FIFO is enabled, the pad is forced inactive while the receive FIFO level is above its trigger threshold. The second selects loopback. In loopback the pad is parked high and the RTS value is returned on an internal line that feeds the clear-to-send input of the modem status logic.

The pad output is registered. It settles at the same rising edge that samples a write or a new FIFO level.

Top module: `uart_rts_ctrl`

## Requirements
- R1: After reset `rts_no` is 1, `loop_cts_o` is 0, and both the modem control word (offset 0x10) and the alias register (offset 0x8C) read as 0.
- R2: A write to the alias register (offset 0x8C) loads wdata bit 0 into the RTS bit. A read of the modem control word then shows that value at bit 1.
- R3: A write to the modem control word (offset 0x10) loads RTS from bit 1, loopback from bit 4 and auto flow control from bit 5. A read of the alias register then returns RTS at bit 0.
- R4: With loopback and auto flow control both clear, `rts_no` equals the inverse of RTS. It takes the new value at the rising edge that samples the write.
- R5: When auto flow control and `fifo_en_i` are both 1, `rts_no` is 1 at each edge where `rx_level_i > rx_thresh_i` (unsigned) or RTS is 0. A level equal to the threshold does not release the pad.
- R6: When `fifo_en_i` is 0 or auto flow control is 0, `rx_level_i` has no effect on `rts_no`.
- R7: With loopback set, `rts_no` is 1 whatever RTS is, and `loop_cts_o` equals RTS. With loopback clear, `loop_cts_o` is 0.
- R8: Reserved bits read as 0: bits 31..1 of the alias register, and every bit of the modem control word except 1, 4 and 5. Writes to reserved bits have no effect, and an alias write leaves loopback and auto flow control unchanged. Addresses other than 0x10 and 0x8C read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (8) | Register byte offset |
| reg_wdata_i | input | DATA_W (32) | Write data |
| reg_rdata_o | output | DATA_W (32) | Read data for `reg_addr_i`, combinational |
| rx_level_i | input | LVL_W (5) | Receive FIFO fill level |
| rx_thresh_i | input | LVL_W (5) | Receive FIFO trigger threshold |
| fifo_en_i | input | 1 | FIFO enable |
| rts_no | output | 1 | Request-to-send pad, active low |
| loop_cts_o | output | 1 | Looped RTS toward the modem status clear-to-send input |

## Verification
Register reads are combinational, so they are due in the same cycle that the address is applied. The bench samples them 1 ns after it changes the address. `rts_no` and `loop_cts_o` are due at the first rising edge after a write, a level change or an enable change has been presented. The driver applies each stimulus at a falling edge and queues the expected value. The monitor then compares at the next falling edge, half a period after the output has settled. The driver does not move to the next stimulus until the monitor has consumed the queued item, so every comparison sees exactly one stimulus.

// File: rtl/uart_rts_pkg.sv
package uart_rts_pkg;
  // bit positions of the modem control word decoded by neighbouring logic
  localparam int unsigned MCR_RTS_BIT  = 1;
  localparam int unsigned MCR_LOOP_BIT = 4;
  localparam int unsigned MCR_AFC_BIT  = 5;
  localparam int unsigned ALIAS_BIT    = 0;

  typedef struct packed {
    logic afc;
    logic loop;
    logic rts;
  } mcr_t;

  localparam mcr_t MCR_RST = '{afc: 1'b0, loop: 1'b0, rts: 1'b0};
endpackage

// File: rtl/uart_rts_regs.sv
module uart_rts_regs
  import uart_rts_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] MCR_OFS   = 8'h10,
  parameter logic [ADDR_W-1:0] ALIAS_OFS = 8'h8C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output mcr_t              mcr_q_o,
  output mcr_t              mcr_d_o
);
  localparam int unsigned MIN_W = MCR_AFC_BIT + 1;

  mcr_t mcr_q, mcr_d;
  logic sel_mcr, sel_alias;

  assign sel_mcr   = (addr_i == MCR_OFS);
  assign sel_alias = (addr_i == ALIAS_OFS);

  always_comb begin
    mcr_d = mcr_q;
    if (we_i && sel_mcr) begin
      mcr_d.rts  = wdata_i[MCR_RTS_BIT];
      mcr_d.loop = wdata_i[MCR_LOOP_BIT];
      mcr_d.afc  = wdata_i[MCR_AFC_BIT];
    end else if (we_i && sel_alias) begin
      // alias touches only the shared RTS flop
      mcr_d.rts = wdata_i[ALIAS_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mcr_q <= MCR_RST;
    else         mcr_q <= mcr_d;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_mcr) begin
      rdata_o[MCR_RTS_BIT]  = mcr_q.rts;
      rdata_o[MCR_LOOP_BIT] = mcr_q.loop;
      rdata_o[MCR_AFC_BIT]  = mcr_q.afc;
    end else if (sel_alias) begin
      rdata_o[ALIAS_BIT] = mcr_q.rts;
    end
  end

  generate
    if (DATA_W < MIN_W) begin : g_bad_width
      initial $error("DATA_W too narrow for the modem control word");
    end
  endgenerate

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign mcr_q_o = mcr_q;
  assign mcr_d_o = mcr_d;
endmodule

// File: rtl/uart_rts_flow.sv
module uart_rts_flow #(
  parameter int unsigned LVL_W = 5
) (
  input  logic             afc_i,
  input  logic             fifo_en_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thresh_i,
  output logic             hold_o
);
  logic above;
  assign above  = (level_i > thresh_i);
  assign hold_o = afc_i && fifo_en_i && above;
endmodule

// File: rtl/uart_rts_drive.sv
module uart_rts_drive
  import uart_rts_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  mcr_t mcr_d_i,
  input  mcr_t mcr_q_i,
  input  logic hold_i,
  output logic rts_no,
  output logic loop_cts_o
);
  logic rts_n_d, rts_n_q;

  // loopback parks the pad inactive; flow hold overrides software RTS
  assign rts_n_d = mcr_d_i.loop ? 1'b1 : !(mcr_d_i.rts && !hold_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rts_n_q <= 1'b1;
    else         rts_n_q <= rts_n_d;
  end

  assign rts_no     = rts_n_q;
  assign loop_cts_o = mcr_q_i.loop && mcr_q_i.rts;
endmodule

// File: rtl/uart_rts_ctrl.sv
module uart_rts_ctrl
  import uart_rts_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LVL_W  = 5,
  parameter logic [ADDR_W-1:0] MCR_OFS   = 8'h10,
  parameter logic [ADDR_W-1:0] ALIAS_OFS = 8'h8C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [LVL_W-1:0]  rx_thresh_i,
  input  logic              fifo_en_i,
  output logic              rts_no,
  output logic              loop_cts_o
);
  mcr_t mcr_q, mcr_d;
  logic hold;
  logic rts_q, loop_q, afc_q;

  uart_rts_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MCR_OFS(MCR_OFS), .ALIAS_OFS(ALIAS_OFS)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .mcr_q_o (mcr_q),
    .mcr_d_o (mcr_d)
  );

  // hold is formed from next-state AFC so the pad and the register move together
  uart_rts_flow #(.LVL_W(LVL_W)) u_flow (
    .afc_i     (mcr_d.afc),
    .fifo_en_i (fifo_en_i),
    .level_i   (rx_level_i),
    .thresh_i  (rx_thresh_i),
    .hold_o    (hold)
  );

  uart_rts_drive u_drive (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mcr_d_i    (mcr_d),
    .mcr_q_i    (mcr_q),
    .hold_i     (hold),
    .rts_no     (rts_no),
    .loop_cts_o (loop_cts_o)
  );

  assign rts_q  = mcr_q.rts;
  assign loop_q = mcr_q.loop;
  assign afc_q  = mcr_q.afc;
endmodule

// File: rtl/uart_rts_ctrl_chk.sv
module uart_rts_ctrl_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LVL_W  = 5,
  parameter logic [ADDR_W-1:0] MCR_OFS   = 8'h10,
  parameter logic [ADDR_W-1:0] ALIAS_OFS = 8'h8C
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic [LVL_W-1:0]  rx_level_i,
  input logic [LVL_W-1:0]  rx_thresh_i,
  input logic              fifo_en_i,
  input logic              rts_no,
  input logic              loop_cts_o,
  input logic              rts_q,
  input logic              loop_q,
  input logic              afc_q
);
  // R4: plain mode pad mirrors stored RTS
  p_pad_follows_rts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loop_q && !afc_q) |-> (rts_no == !rts_q));

  // R5: level above threshold under auto flow control releases the pad
  p_afc_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (afc_q && $past(fifo_en_i) && $past(rx_level_i > rx_thresh_i)) |-> rts_no);

  // R6: flow gating off, level has no say
  p_no_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loop_q && afc_q && !$past(fifo_en_i)) |-> (rts_no == !rts_q));

  // R7: loopback parks the pad
  p_loop_park_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_q |-> rts_no);

  // R7: looped line agrees with the alias read path
  p_loop_cts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_q && reg_addr_i == ALIAS_OFS) |-> (loop_cts_o == reg_rdata_o[0]));

  // R8: alias register reserved bits read zero
  p_alias_rsvd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ALIAS_OFS) |-> (reg_rdata_o[DATA_W-1:1] == '0));

  // R2/R3: both read paths agree on RTS
  p_paths_agree_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == MCR_OFS) |-> (reg_rdata_o[1] == rts_q));
endmodule

bind uart_rts_ctrl uart_rts_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W),
  .MCR_OFS(MCR_OFS), .ALIAS_OFS(ALIAS_OFS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .rx_level_i  (rx_level_i),
  .rx_thresh_i (rx_thresh_i),
  .fifo_en_i   (fifo_en_i),
  .rts_no      (rts_no),
  .loop_cts_o  (loop_cts_o),
  .rts_q       (rts_q),
  .loop_q      (loop_q),
  .afc_q       (afc_q)
);

// File: tb/uart_rts_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_rts_ctrl_tb_top;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int LVL_W  = 5;
  localparam logic [7:0] A_MCR   = 8'h10;
  localparam logic [7:0] A_ALIAS = 8'h8C;
  localparam logic [7:0] A_NONE  = 8'h40;

  typedef enum int {K_PAD, K_RD, K_CTS} kind_e;
  typedef struct {
    string       req;
    kind_e       kind;
    logic [31:0] exp;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [LVL_W-1:0]  level = '0;
  logic [LVL_W-1:0]  thresh = 5'd8;
  logic              fen = 1'b0;
  logic              rts_n, cts;

  item_t q[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_rts_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rx_level_i(level),
    .rx_thresh_i(thresh), .fifo_en_i(fen), .rts_no(rts_n), .loop_cts_o(cts)
  );

  // monitor
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      wait (q.size() > 0);
      it = q.pop_front();
      case (it.kind)
        K_PAD:   act = {31'd0, rts_n};
        K_CTS:   act = {31'd0, cts};
        default: act = rdata;
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.req, act, it.exp);
      end
    end
  end

  task automatic expect_v(input string req, input kind_e k, input logic [31:0] e);
    item_t it;
    it.req = req; it.kind = k; it.exp = e;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] e);
    addr = a; #1;
    expect_v(req, K_RD, e);
  endtask

  task automatic set_in(input logic [LVL_W-1:0] l, input logic f);
    @(negedge clk); level = l; fen = f;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_v("R1 pad", K_PAD, 1);
    expect_v("R1 cts", K_CTS, 0);
    rd_chk("R1 mcr", A_MCR, 0);
    rd_chk("R1 alias", A_ALIAS, 0);

    // R2 alias write, R4 pad on the write edge
    wr(A_ALIAS, 32'h1);
    expect_v("R4 pad low", K_PAD, 0);
    rd_chk("R2 mcr bit1", A_MCR, 32'h2);

    // R3 full word write
    wr(A_MCR, 32'h0);
    expect_v("R4 pad high", K_PAD, 1);
    rd_chk("R3 alias clr", A_ALIAS, 0);
    wr(A_MCR, 32'h2);
    rd_chk("R3 alias set", A_ALIAS, 32'h1);
    expect_v("R3 pad", K_PAD, 0);

    // R8 reserved bits
    wr(A_MCR, 32'hFFFF_FFFF);
    rd_chk("R8 mcr rsvd", A_MCR, 32'h32);
    rd_chk("R8 alias rsvd", A_ALIAS, 32'h1);
    wr(A_ALIAS, 32'hFFFF_FFFE);
    rd_chk("R8 alias keeps loop/afc", A_MCR, 32'h30);
    wr(A_MCR, 32'h2);
    wr(A_NONE, 32'hFFFF_FFFF);
    rd_chk("R8 unmapped write", A_MCR, 32'h2);
    rd_chk("R8 unmapped read", A_NONE, 0);

    // R5 auto flow control
    wr(A_MCR, 32'h22);
    set_in(5'd8, 1'b1);
    expect_v("R5 level equal", K_PAD, 0);
    set_in(5'd9, 1'b1);
    expect_v("R5 above", K_PAD, 1);
    set_in(5'd8, 1'b1);
    expect_v("R5 back", K_PAD, 0);
    wr(A_ALIAS, 32'h0);
    expect_v("R5 rts off", K_PAD, 1);
    wr(A_ALIAS, 32'h1);

    // R6 gating off
    set_in(5'd12, 1'b0);
    expect_v("R6 fifo off", K_PAD, 0);
    set_in(5'd12, 1'b1);
    expect_v("R6 fifo on", K_PAD, 1);
    wr(A_MCR, 32'h2);
    expect_v("R6 afc off", K_PAD, 0);

    // R7 loopback
    wr(A_MCR, 32'h12);
    expect_v("R7 parked", K_PAD, 1);
    expect_v("R7 cts set", K_CTS, 1);
    wr(A_ALIAS, 32'h0);
    expect_v("R7 cts clr", K_CTS, 0);
    expect_v("R7 parked2", K_PAD, 1);
    rd_chk("R7 loop kept", A_MCR, 32'h10);
    wr(A_MCR, 32'h2);
    expect_v("R7 exit pad", K_PAD, 0);
    expect_v("R7 exit cts", K_CTS, 0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule